// File: doc/BRIEF.md
# External Bus Cycle Controller

This block is the master side of a simple external bus. It takes one request at a time from the chip: an address, attributes, a direction and write data. It turns each request into a single read or write cycle on the pins, then returns read data together with a one-clock completion pulse. The block runs on a core clock at twice the bus rate. It generates the bus clock itself, so every bus clock has a high half-state followed by a low half-state. Every pin event is placed on one particular half.

A cycle is one address clock, then one or more data clocks, then a hold clock that keeps address, attributes and write data stable. The transfer-start strobe covers the address clock. The address strobe falls in the low half of the address clock and rises when the hold clock begins. The data clock repeats until an acknowledge is seen at the end of its low half.

The acknowledge comes either from an internal wait counter or from the external device. Which one is used follows from the region hits that the requester presents with the request: chip-select hits and memory-controller hits. A combination of hits with no defined meaning is flagged on an error output, and the cycle is ended internally.

Top module: `ebc_bus_ctrl`

## Requirements
- R1: During reset and while idle, `ts_n_o`, `as_n_o` are 1 and `data_oe_o`, `done_o`, `err_o`, `wide_o` are 0. `bclk_o` is 1 in reset and then toggles every core clock, so that even half-states are high and odd half-states are low.
- R2: A request is taken in a low half-state while idle. The cycle begins on the next high half. `ts_n_o` is 0 for exactly that bus clock (two core clocks). `addr_o`, `attr_o` and `rd_o` show the request from that half until the cycle ends.
- R3: `as_n_o` falls in the low half of the address clock and stays 0 through every data clock. It is 1 again from the first half of the hold clock.
- R4: For writes (`req_rd_i`=0), `data_oe_o` is 1 and `data_o` carries the write data from the first data half-state to the end of the hold clock. For reads, `data_oe_o` stays 0.
- R5: The acknowledge and, on reads, `data_i` are sampled at the rising bus edge that ends a data clock. `done_o` is a one-core-clock pulse in the first half of the hold clock, and `rdata_o` holds the sampled data from then on.
- R6: With internal acknowledge, a per-region wait count W (0..15) gives W+1 data clocks, whatever `ta_n_i` does. Region i's count sits in bits [i*4 +: 4] of its wait vector.
- R7: With external acknowledge, the data clock repeats until `ta_n_i`=0 is seen at the end of a low half. A 0 driven only during high halves has no effect.
- R8: No hits selects external acknowledge. One chip-select hit alone uses that region's internal-acknowledge bit and wait count. One memory-controller hit alone does the same from the memory-controller vectors.
- R9: Two or more chip-select hits with no memory-controller hit give an external-acknowledge cycle, and `wide_o` is 1 for the whole cycle (a forced 32-bit, no-burst access).
- R10: Any other hit combination raises `err_o` together with `done_o`. The cycle ends on an internal acknowledge with zero wait (one data clock).
- R11: A new cycle cannot start before the hold clock has completed. If `req_i` stays at 1, the next cycle starts one bus clock after the hold clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request level, to be dropped once done_o is seen |
| req_addr_i | input | AW | Request address |
| req_attr_i | input | ATW | Request attributes |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_wdata_i | input | DW | Write data |
| cs_hit_i | input | NCS | Chip-select region hits |
| mc_hit_i | input | NMC | Memory-controller region hits |
| cs_wait_i | input | NCS*WW | Chip-select wait counts, WW bits per region |
| cs_iack_i | input | NCS | Chip-select internal-acknowledge enables |
| mc_wait_i | input | NMC*WW | Memory-controller wait counts |
| mc_iack_i | input | NMC | Memory-controller internal-acknowledge enables |
| ta_n_i | input | 1 | External transfer acknowledge, active low |
| data_i | input | DW | Read data from the bus |
| bclk_o | output | 1 | Bus clock |
| addr_o | output | AW | Bus address |
| attr_o | output | ATW | Bus attributes |
| rd_o | output | 1 | Bus direction, 1 = read |
| ts_n_o | output | 1 | Transfer-start strobe, active low |
| as_n_o | output | 1 | Address strobe, active low |
| data_o | output | DW | Write data onto the bus |
| data_oe_o | output | 1 | Write data drive enable |
| done_o | output | 1 | Transfer complete pulse |
| rdata_o | output | DW | Read data returned |
| err_o | output | 1 | Undefined region hit combination |
| wide_o | output | 1 | Forced 32-bit, burst-inhibited cycle |

## Verification
Count core clocks from the clock after the edge that takes the request (half-state 0). For D data clocks, the strobes are due at half-states 0 to 1, 1 to 2D+1 and 2 to 2D+3, and `done_o`, `err_o` and `rdata_o` are due at half-state 2D+2. The bench model counts half-states from the same taking edge and predicts every output for every core clock. It compares these at the falling core-clock edge, after all registers have settled. The bench drives `ta_n_i` for the low half where the acknowledge should land, and also drives it in high halves and on internal-acknowledge cycles, so a wrongly placed sample shows up as an early or late hold clock.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  typedef enum logic [2:0] {
    ACC_EXT,
    ACC_CS,
    ACC_WIDE,
    ACC_MC,
    ACC_BAD
  } acc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADR_H,
    ST_ADR_L,
    ST_DAT_H,
    ST_DAT_L,
    ST_HLD_H,
    ST_HLD_L
  } bus_st_e;

  // Classify an access from the number of chip-select and memory-controller hits
  function automatic acc_kind_e classify(input int unsigned n_cs, input int unsigned n_mc);
    if (n_mc == 0) begin
      if (n_cs == 0)      return ACC_EXT;
      else if (n_cs == 1) return ACC_CS;
      else                return ACC_WIDE;
    end
    if (n_mc == 1 && n_cs == 0) return ACC_MC;
    return ACC_BAD;
  endfunction

endpackage

// File: rtl/ebc_half_phase.sv
module ebc_half_phase (
  input  logic clk,
  input  logic rst_n,
  output logic low_half_o
);
  logic ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  assign low_half_o = ph_q;
endmodule

// File: rtl/ebc_wait_ctr.sv
module ebc_wait_ctr #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [WW-1:0] val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (dec_i && !zero_o) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ebc_region_decode.sv
module ebc_region_decode
  import ebc_pkg::*;
#(
  parameter int NCS = 4,
  parameter int NMC = 2,
  parameter int WW  = 4
) (
  input  logic [NCS-1:0]    cs_hit_i,
  input  logic [NMC-1:0]    mc_hit_i,
  input  logic [NCS*WW-1:0] cs_wait_i,
  input  logic [NCS-1:0]    cs_iack_i,
  input  logic [NMC*WW-1:0] mc_wait_i,
  input  logic [NMC-1:0]    mc_iack_i,
  output acc_kind_e         kind_o,
  output logic              int_ack_o,
  output logic [WW-1:0]     wait_o
);
  function automatic int unsigned pop_cs(input logic [NCS-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < NCS; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int unsigned pop_mc(input logic [NMC-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < NMC; i++) n += int'(v[i]);
    return n;
  endfunction

  logic [WW-1:0] cs_w_sel, mc_w_sel;
  logic          cs_a_sel, mc_a_sel;

  // Only consulted when exactly one hit is present, so an OR over hits selects it
  always_comb begin
    cs_w_sel = '0;
    cs_a_sel = 1'b0;
    for (int i = 0; i < NCS; i++) begin
      if (cs_hit_i[i]) begin
        cs_w_sel = cs_w_sel | cs_wait_i[i*WW +: WW];
        cs_a_sel = cs_a_sel | cs_iack_i[i];
      end
    end
    mc_w_sel = '0;
    mc_a_sel = 1'b0;
    for (int j = 0; j < NMC; j++) begin
      if (mc_hit_i[j]) begin
        mc_w_sel = mc_w_sel | mc_wait_i[j*WW +: WW];
        mc_a_sel = mc_a_sel | mc_iack_i[j];
      end
    end
  end

  always_comb begin
    kind_o = classify(pop_cs(cs_hit_i), pop_mc(mc_hit_i));
    unique case (kind_o)
      ACC_CS:  begin int_ack_o = cs_a_sel; wait_o = cs_w_sel; end
      ACC_MC:  begin int_ack_o = mc_a_sel; wait_o = mc_w_sel; end
      ACC_BAD: begin int_ack_o = 1'b1;     wait_o = '0;       end
      default: begin int_ack_o = 1'b0;     wait_o = '0;       end
    endcase
  end
endmodule

// File: rtl/ebc_bus_ctrl.sv
module ebc_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int ATW = 4,
  parameter int NCS = 4,
  parameter int NMC = 2,
  parameter int WW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [ATW-1:0]    req_attr_i,
  input  logic              req_rd_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [NCS-1:0]    cs_hit_i,
  input  logic [NMC-1:0]    mc_hit_i,
  input  logic [NCS*WW-1:0] cs_wait_i,
  input  logic [NCS-1:0]    cs_iack_i,
  input  logic [NMC*WW-1:0] mc_wait_i,
  input  logic [NMC-1:0]    mc_iack_i,
  input  logic              ta_n_i,
  input  logic [DW-1:0]     data_i,
  output logic              bclk_o,
  output logic [AW-1:0]     addr_o,
  output logic [ATW-1:0]    attr_o,
  output logic              rd_o,
  output logic              ts_n_o,
  output logic              as_n_o,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  output logic              wide_o
);
  bus_st_e       st_q, st_d;
  logic          low_half;
  acc_kind_e     dec_kind, kind_q;
  logic          dec_iack, iack_q;
  logic [WW-1:0] dec_wait;
  logic          wait_zero;
  logic [AW-1:0] addr_q;
  logic [ATW-1:0] attr_q;
  logic          rd_q;
  logic [DW-1:0] wdata_q, rdata_q;

  // Named internal events, observed by the checker
  logic busy, acc_start, ack_hit;

  ebc_half_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .low_half_o (low_half)
  );

  ebc_region_decode #(.NCS(NCS), .NMC(NMC), .WW(WW)) u_dec (
    .cs_hit_i  (cs_hit_i),
    .mc_hit_i  (mc_hit_i),
    .cs_wait_i (cs_wait_i),
    .cs_iack_i (cs_iack_i),
    .mc_wait_i (mc_wait_i),
    .mc_iack_i (mc_iack_i),
    .kind_o    (dec_kind),
    .int_ack_o (dec_iack),
    .wait_o    (dec_wait)
  );

  assign busy      = (st_q != ST_IDLE);
  assign acc_start = (st_q == ST_IDLE) && low_half && req_i;
  assign ack_hit   = (st_q == ST_DAT_L) && (iack_q ? wait_zero : !ta_n_i);

  ebc_wait_ctr #(.WW(WW)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (acc_start),
    .val_i  (dec_wait),
    .dec_i  (st_q == ST_DAT_L),
    .zero_o (wait_zero)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (acc_start) st_d = ST_ADR_H;
      ST_ADR_H: st_d = ST_ADR_L;
      ST_ADR_L: st_d = ST_DAT_H;
      ST_DAT_H: st_d = ST_DAT_L;
      ST_DAT_L: st_d = ack_hit ? ST_HLD_H : ST_DAT_H;
      ST_HLD_H: st_d = ST_HLD_L;
      ST_HLD_L: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= ACC_EXT;
      iack_q  <= 1'b0;
      addr_q  <= '0;
      attr_q  <= '0;
      rd_q    <= 1'b1;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (acc_start) begin
        kind_q  <= dec_kind;
        iack_q  <= dec_iack;
        addr_q  <= req_addr_i;
        attr_q  <= req_attr_i;
        rd_q    <= req_rd_i;
        wdata_q <= req_wdata_i;
      end
      if (ack_hit && rd_q) rdata_q <= data_i;
    end
  end

  assign bclk_o    = ~low_half;
  assign addr_o    = addr_q;
  assign attr_o    = attr_q;
  assign rd_o      = rd_q;
  assign data_o    = wdata_q;
  assign rdata_o   = rdata_q;
  assign ts_n_o    = !(st_q == ST_ADR_H || st_q == ST_ADR_L);
  assign as_n_o    = !(st_q == ST_ADR_L || st_q == ST_DAT_H || st_q == ST_DAT_L);
  assign data_oe_o = !rd_q && (st_q == ST_DAT_H || st_q == ST_DAT_L ||
                               st_q == ST_HLD_H || st_q == ST_HLD_L);
  assign done_o    = (st_q == ST_HLD_H);
  assign err_o     = done_o && (kind_q == ACC_BAD);
  assign wide_o    = busy && (kind_q == ACC_WIDE);
endmodule

// File: rtl/ebc_bus_ctrl_chk.sv
module ebc_bus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_o,
  input logic ts_n_o,
  input logic as_n_o,
  input logic data_oe_o,
  input logic done_o,
  input logic err_o,
  input logic rd_o,
  input logic acc_start,
  input logic ack_hit
);
  // R2
  ts_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ts_n_o) |-> bclk_o);
  // R2
  ts_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ts_n_o) |=> !ts_n_o ##1 ts_n_o);
  // R3
  as_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_n_o) |-> !bclk_o);
  // R3
  hold_negated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> as_n_o && ts_n_o);
  // R4
  wdata_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> !as_n_o && ts_n_o && !rd_o);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5
  ack_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> done_o);
  // R7
  ack_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |-> !bclk_o);
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
  // R11
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |-> ts_n_o && as_n_o && !data_oe_o);
endmodule

bind ebc_bus_ctrl ebc_bus_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bclk_o    (bclk_o),
  .ts_n_o    (ts_n_o),
  .as_n_o    (as_n_o),
  .data_oe_o (data_oe_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .rd_o      (rd_o),
  .acc_start (acc_start),
  .ack_hit   (ack_hit)
);

// File: tb/ebc_bus_ctrl_tb.sv
module ebc_bus_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [3:0]  req_attr_i = '0;
  logic        req_rd_i = 1'b1;
  logic [31:0] req_wdata_i = '0;
  logic [3:0]  cs_hit_i = '0;
  logic [1:0]  mc_hit_i = '0;
  logic [15:0] cs_wait_i;
  logic [3:0]  cs_iack_i;
  logic [7:0]  mc_wait_i;
  logic [1:0]  mc_iack_i;
  logic        ta_n_i = 1'b1;
  logic [31:0] data_i = '0;
  logic        bclk_o, rd_o, ts_n_o, as_n_o, data_oe_o, done_o, err_o, wide_o;
  logic [31:0] addr_o, data_o, rdata_o;
  logic [3:0]  attr_o;

  int checks = 0;
  int errors = 0;

  // Region setup: cs0 W=2 int, cs1 W=0 int, cs2 external, cs3 W=15 int; mc0 W=1 int, mc1 external
  assign cs_wait_i = {4'd15, 4'd0, 4'd0, 4'd2};
  assign cs_iack_i = 4'b1011;
  assign mc_wait_i = {4'd0, 4'd1};
  assign mc_iack_i = 2'b01;

  always #5 clk = ~clk;

  ebc_bus_ctrl u_dut (.*);

  // Expectation for the next accepted transfer
  int          nx_d = 1;
  bit          nx_ext = 0, nx_bad = 0, nx_wide = 0, nx_rd = 1;
  logic [31:0] nx_addr = '0, nx_wdata = '0, nx_rval = '0;
  logic [3:0]  nx_attr = '0;

  // Reference model: half-state count since the accepting edge
  bit          m_ph = 0, m_busy = 0;
  int          k = 0, m_d = 1;
  bit          m_ext = 0, m_bad = 0, m_wide = 0, m_rd = 1;
  logic [31:0] m_addr = '0, m_wdata = '0, m_rval = '0, m_rdata = '0;
  logic [3:0]  m_attr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_busy = 0; k = 0; m_rdata = '0;
    end else begin
      if (m_busy) begin
        k++;
        if (k == 2 + 2 * m_d && m_rd) m_rdata = m_rval;
        if (k == 4 + 2 * m_d) m_busy = 0;
      end else if (m_ph && req_i) begin
        m_busy = 1; k = 0;
        m_d = nx_d; m_ext = nx_ext; m_bad = nx_bad; m_wide = nx_wide; m_rd = nx_rd;
        m_addr = nx_addr; m_attr = nx_attr; m_wdata = nx_wdata; m_rval = nx_rval;
      end
      m_ph = !m_ph;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(ts_n_o && as_n_o && !data_oe_o && !done_o && !err_o && !wide_o && bclk_o,
          "R1", "reset idle", {ts_n_o, as_n_o, data_oe_o, done_o, err_o, wide_o, bclk_o}, 7'b1100001);
    end else begin
      logic e_ts, e_as, e_oe, e_done;
      e_ts   = !(m_busy && k < 2);
      e_as   = !(m_busy && k >= 1 && k < 2 + 2 * m_d);
      e_oe   = m_busy && !m_rd && k >= 2;
      e_done = m_busy && k == 2 + 2 * m_d;
      chk(bclk_o == !m_ph, "R1", "bclk", bclk_o, !m_ph);
      chk(ts_n_o == e_ts, "R2", "ts_n", ts_n_o, e_ts);
      chk(as_n_o == e_as, "R3", "as_n", as_n_o, e_as);
      chk(data_oe_o == e_oe, "R4", "data_oe", data_oe_o, e_oe);
      chk(done_o == e_done, "R5", "done", done_o, e_done);
      chk(wide_o == (m_busy && m_wide), "R9", "wide", wide_o, m_busy && m_wide);
      chk(err_o == (e_done && m_bad), "R10", "err", err_o, e_done && m_bad);
      if (m_busy) begin
        chk(addr_o == m_addr && attr_o == m_attr && rd_o == m_rd, "R2", "addr/attr/rd",
            addr_o, m_addr);
        if (e_oe) chk(data_o == m_wdata, "R4", "wdata", data_o, m_wdata);
      end
      if (e_done && m_rd) chk(rdata_o == m_rdata, "R5", "rdata", rdata_o, m_rdata);
      // Acknowledge stimulus for the coming edge; decoys in high halves and on internal cycles
      if (m_busy && k >= 2 && k < 2 + 2 * m_d) begin
        if (!m_ext)            ta_n_i = 1'b0;          // R6 ignored
        else if (k % 2 == 0)   ta_n_i = 1'b0;          // R7 high half ignored
        else                   ta_n_i = (k != 1 + 2 * m_d);
        data_i = (k == 1 + 2 * m_d) ? m_rval : ~m_rval;
      end else begin
        ta_n_i = 1'b1;
        data_i = 32'hdead_beef;
      end
    end
  end

  task automatic xfer(input bit rd, input logic [31:0] a, input logic [31:0] wd,
                      input logic [3:0] cs, input logic [1:0] mc, input int d,
                      input bit ext, input bit bad, input bit wide, input bit keep);
    @(negedge clk);
    nx_d = d; nx_ext = ext; nx_bad = bad; nx_wide = wide; nx_rd = rd;
    nx_addr = a; nx_attr = a[3:0]; nx_wdata = wd; nx_rval = a ^ 32'h5a5a_0f0f;
    req_addr_i = a; req_attr_i = a[3:0]; req_rd_i = rd; req_wdata_i = wd;
    cs_hit_i = cs; mc_hit_i = mc; req_i = 1'b1;
    while (!m_busy) @(negedge clk);
    while (m_busy) @(negedge clk);
    if (!keep) req_i = 1'b0;
  endtask

  initial begin
    int wd = 0;
    while (wd < 20000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<%0d", wd, 20000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    xfer(1, 32'h1000_0011, 0,            4'b0001, 2'b00, 3,  0, 0, 0, 0); // R6 R8 cs0 W=2
    xfer(0, 32'h1000_0022, 32'hcafe0001, 4'b0010, 2'b00, 1,  0, 0, 0, 0); // R4 R6 cs1 W=0
    xfer(1, 32'h1000_0033, 0,            4'b1000, 2'b00, 16, 0, 0, 0, 0); // R6 cs3 W=15
    xfer(1, 32'h2000_0044, 0,            4'b0000, 2'b00, 1,  1, 0, 0, 0); // R7 R8 no hit
    xfer(0, 32'h2000_0055, 32'hcafe0002, 4'b0000, 2'b00, 4,  1, 0, 0, 0); // R7 R4 ext waits
    xfer(1, 32'h3000_0066, 0,            4'b0100, 2'b00, 2,  1, 0, 0, 0); // R8 cs2 external
    xfer(0, 32'h3000_0077, 32'hcafe0003, 4'b0011, 2'b00, 1,  1, 0, 1, 0); // R9 two cs
    xfer(1, 32'h3000_0078, 0,            4'b1110, 2'b00, 3,  1, 0, 1, 0); // R9 three cs
    xfer(1, 32'h4000_0088, 0,            4'b0000, 2'b01, 2,  0, 0, 0, 0); // R8 mc0 W=1
    xfer(0, 32'h4000_0099, 32'hcafe0004, 4'b0000, 2'b10, 3,  1, 0, 0, 0); // R8 mc1 external
    xfer(1, 32'h5000_00aa, 0,            4'b0001, 2'b01, 1,  0, 1, 0, 0); // R10 cs+mc
    xfer(0, 32'h5000_00bb, 32'hcafe0005, 4'b0000, 2'b11, 1,  0, 1, 0, 0); // R10 two mc
    xfer(1, 32'h6000_00cc, 0,            4'b0001, 2'b00, 3,  0, 0, 0, 1); // R11 held req
    xfer(0, 32'h6000_00dd, 32'hcafe0006, 4'b0010, 2'b00, 1,  0, 0, 0, 1); // R11 back to back
    xfer(1, 32'h6000_00ee, 0,            4'b0000, 2'b00, 2,  1, 0, 0, 0); // R11 R7
    repeat (6) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule